// File: doc/BRIEF.md
# Data Cache Maintenance Controller

This block carries out maintenance on a small direct-mapped write-back data cache model. It owns the per-set state array (valid bit, dirty bit and tag) and a write-back request port to the next memory level. Software reaches it through a small register interface with five registers:

- a control register;
- two whole-cache command registers, one to invalidate and one to flush;
- two single-line command registers, which take a byte address.

A flush writes dirty lines back and keeps them resident. An invalidate drops lines. A mode bit in the control register decides whether an invalidate first writes back the dirty lines it drops, which gives a combined flush-and-invalidate through the invalidate registers. Whole-cache commands visit one set per cycle. Every dirty line that must be written back raises one valid/ready request. Software polls a status bit in the control register until the operation has finished.

Filling the array is not part of this block. A fill port stands in for the normal refill path, and a lookup port reports the hit and dirty state for an address. The bench uses these two ports to prepare the array and to observe it. Register writes that arrive while an operation is still running are stalled with a wait signal.

Top module: `dcm_ctrl`

## Requirements
- R1: After reset the control register reads 0 (enabled, mode 0, status 0), no line hits, and wb_valid is low.
- R2: Register select 0 is the control register. Bit 0 is the disable bit and bit 6 is the mode bit, and both are read/write. Bit 8 is a read-only status bit: writing it has no effect. All other bits read 0.
- R3: While the disable bit is 1, command writes are accepted without wait but have no effect: the array is unchanged, no write-back is issued and status stays 0. Writing 0 to the control register re-enables the cache.
- R4: With mode 0, a write of any value to select 1 (invalidate all) leaves every line invalid and issues no write-back.
- R5: With mode 1, invalidate-all writes back every valid dirty line, in ascending set order, and leaves every line invalid.
- R6: A write of any value to select 2 (flush all) writes back every valid dirty line in ascending set order. The lines stay valid and become clean. The write-back address is the line base: tag, then set index, then zero offset.
- R7: A write of an address to select 4 (flush line) or select 3 (invalidate line) acts only on the set given by address bits [OFF+IDX-1:OFF], and only when that line is valid and its tag equals the address bits above the index. The low offset bits are ignored. On a tag mismatch or an invalid line the command has no effect.
- R8: Status reads 1 from the cycle after a command is accepted until the operation completes. A whole-cache operation with no write-backs keeps status at 1 for exactly SETS cycles, and each write-back accepted at once adds one cycle. Status does not clear before the last write-back handshake.
- R9: Once wb_valid is raised, it stays high with wb_addr unchanged until wb_ready is seen high.
- R10: A register write made while status is 1 is held with reg_wait high and takes effect once the operation ends. Reads never wait.
- R11: With mode 0, a line invalidate drops a dirty line without a write-back. With mode 1 it writes the line back first and then drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select: 0 control, 1 invalidate all, 2 flush all, 3 invalidate line, 4 flush line |
| reg_wdata | input | ADDR_W | Write data, or a byte address for line commands |
| reg_rdata | output | ADDR_W | Read data, combinational |
| reg_wait | output | 1 | Write stalled while an operation runs |
| fill_en | input | 1 | Install a line (ignored while busy) |
| fill_addr | input | ADDR_W | Byte address of the installed line |
| fill_dirty | input | 1 | Dirty state of the installed line |
| look_addr | input | ADDR_W | Lookup byte address |
| look_hit | output | 1 | Line for look_addr is valid and its tag matches |
| look_dirty | output | 1 | Dirty bit of the looked-up set |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | ADDR_W | Line base address of the write-back |

## Verification
The bench goes after the ordering and the completion edge of the walk. It checks that dirty lines come out in ascending set order, and that a wrong index step shows up as a reordered or missing write-back address. It counts status cycles exactly, so an engine that drops status one cycle early, or that adds a bubble per set, misreports the count. A stuck write-back with wb_ready held low checks that status is held and that a control write stalls instead of changing the mode mid-operation. Line commands are tried with a wrong tag and with non-zero offset bits: an engine that ignores the tag would clean or drop a line it should leave alone. The disabled case checks that a dirty line survives both command kinds with no write-back.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  typedef enum logic [2:0] {
    RA_CTRL       = 3'd0,
    RA_ALL_INV    = 3'd1,
    RA_ALL_FLUSH  = 3'd2,
    RA_LINE_INV   = 3'd3,
    RA_LINE_FLUSH = 3'd4
  } reg_sel_e;

  localparam int CTRL_DIS_BIT  = 0;
  localparam int CTRL_MODE_BIT = 6;
  localparam int CTRL_STAT_BIT = 8;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_SCAN = 2'd1,
    ENG_WB   = 2'd2
  } eng_state_e;

  typedef struct packed {
    logic whole;      // walk every set
    logic inv;        // drop lines after processing
    logic wb_on_inv;  // invalidate writes dirty lines back first
  } op_cfg_t;

endpackage

// File: rtl/dcm_regif.sv
module dcm_regif
  import dcm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              busy,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              reg_wait,
  output logic              ctrl_dis,
  output logic              ctrl_mode,
  output logic              cmd_accept,
  output logic              cmd_start,
  output op_cfg_t           cmd_cfg,
  output logic [IDX_W-1:0]  cmd_idx,
  output logic [TAG_W-1:0]  cmd_tag
);

  function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[OFF_W+IDX_W +: TAG_W];
  endfunction

  reg_sel_e sel;
  logic     wr_ok;
  logic     is_cmd;
  logic     sel_whole;
  logic     sel_inv;
  logic     dis_q;
  logic     mode_q;
  logic     unused_wbits;

  assign sel          = reg_sel_e'(reg_addr);
  assign wr_ok        = reg_wr && !busy;
  assign reg_wait     = reg_wr && busy;
  assign unused_wbits = ^reg_wdata[OFF_W-1:1];

  always_comb begin
    is_cmd    = 1'b0;
    sel_whole = 1'b0;
    sel_inv   = 1'b0;
    case (sel)
      RA_ALL_INV:    begin is_cmd = 1'b1; sel_whole = 1'b1; sel_inv = 1'b1; end
      RA_ALL_FLUSH:  begin is_cmd = 1'b1; sel_whole = 1'b1; end
      RA_LINE_INV:   begin is_cmd = 1'b1; sel_inv = 1'b1; end
      RA_LINE_FLUSH: begin is_cmd = 1'b1; end
      default:       ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (wr_ok && sel == RA_CTRL) begin
      dis_q  <= reg_wdata[CTRL_DIS_BIT];
      mode_q <= reg_wdata[CTRL_MODE_BIT];
    end
  end

  assign ctrl_dis   = dis_q;
  assign ctrl_mode  = mode_q;
  assign cmd_accept = wr_ok && is_cmd;
  assign cmd_start  = cmd_accept && !dis_q;

  always_comb begin
    cmd_cfg.whole     = sel_whole;
    cmd_cfg.inv       = sel_inv;
    cmd_cfg.wb_on_inv = mode_q;
  end

  assign cmd_idx = addr_index(reg_wdata);
  assign cmd_tag = addr_tag(reg_wdata);

  always_comb begin
    reg_rdata = '0;
    if (reg_rd && sel == RA_CTRL) begin
      reg_rdata[CTRL_DIS_BIT]  = dis_q;
      reg_rdata[CTRL_MODE_BIT] = mode_q;
      reg_rdata[CTRL_STAT_BIT] = busy;
    end
  end

endmodule

// File: rtl/dcm_tag_array.sv
module dcm_tag_array #(
  parameter int SETS  = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_valid,
  input  logic             upd_dirty,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic             lk_dirty,
  output logic [TAG_W-1:0] lk_tag
);

  logic             valid_q [SETS];
  logic             dirty_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic hit_upd;
    logic hit_fill;
    assign hit_upd  = upd_en  && (upd_idx  == IDX_W'(g));
    assign hit_fill = fill_en && (fill_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else if (hit_upd) begin
        valid_q[g] <= upd_valid;
        dirty_q[g] <= upd_dirty;
      end else if (hit_fill) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= fill_dirty;
        tag_q[g]   <= fill_tag;
      end
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign lk_valid = valid_q[lk_idx];
  assign lk_dirty = dirty_q[lk_idx];
  assign lk_tag   = tag_q[lk_idx];

endmodule

// File: rtl/dcm_engine.sv
module dcm_engine
  import dcm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 23,
  parameter int SETS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_cfg_t           start_cfg,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [TAG_W-1:0]  start_tag,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_valid,
  input  logic              rd_dirty,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              upd_en,
  output logic [IDX_W-1:0]  upd_idx,
  output logic              upd_valid,
  output logic              upd_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              busy,
  output op_cfg_t           cur_cfg,
  output logic              op_done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SETS - 1);

  function automatic logic [ADDR_W-1:0] line_base(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i, OFF_W'(0)};
  endfunction

  eng_state_e       state_q, state_d;
  op_cfg_t          cfg_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [TAG_W-1:0] tag_q;

  logic line_act;   // set under the cursor is a target
  logic need_wb;    // target must be written back
  logic last_set;   // no further set after this one
  logic step;       // current set finished

  assign rd_idx   = idx_q;
  assign line_act = rd_valid && (cfg_q.whole || rd_tag == tag_q);
  assign need_wb  = line_act && rd_dirty && (!cfg_q.inv || cfg_q.wb_on_inv);
  assign last_set = !cfg_q.whole || idx_q == LAST_IDX;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    step      = 1'b0;
    upd_en    = 1'b0;
    upd_valid = 1'b0;
    upd_dirty = 1'b0;
    wb_valid  = 1'b0;
    case (state_q)
      ENG_SCAN: begin
        if (need_wb) begin
          state_d = ENG_WB;
        end else begin
          step = 1'b1;
          if (line_act && cfg_q.inv) begin
            upd_en = 1'b1;
          end
        end
      end
      ENG_WB: begin
        wb_valid = 1'b1;
        if (wb_ready) begin
          step      = 1'b1;
          upd_en    = 1'b1;
          upd_valid = !cfg_q.inv;
        end
      end
      default: ;
    endcase
    if (step) begin
      if (last_set) begin
        state_d = ENG_IDLE;
      end else begin
        state_d = ENG_SCAN;
        idx_d   = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cfg_q   <= '0;
      idx_q   <= '0;
      tag_q   <= '0;
    end else if (state_q == ENG_IDLE) begin
      if (start) begin
        state_q <= ENG_SCAN;
        cfg_q   <= start_cfg;
        idx_q   <= start_cfg.whole ? '0 : start_idx;
        tag_q   <= start_tag;
      end
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign upd_idx = idx_q;
  assign wb_addr = line_base(rd_tag, idx_q);
  assign busy    = state_q != ENG_IDLE;
  assign cur_cfg = cfg_q;
  assign op_done = step && last_set;

endmodule

// File: rtl/dcm_ctrl.sv
module dcm_ctrl
  import dcm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              reg_wait,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_dirty,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              look_hit,
  output logic              look_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  // named internal events, observed by the bound checker
  logic             eng_busy;
  logic             cmd_accept;
  logic             cmd_start;
  logic             ctrl_dis;
  logic             ctrl_mode;
  logic             op_done;
  op_cfg_t          cmd_cfg;
  op_cfg_t          cur_cfg;
  logic             cur_inv;
  logic             cur_wb_on_inv;
  logic [IDX_W-1:0] cmd_idx;
  logic [TAG_W-1:0] cmd_tag;

  logic [IDX_W-1:0] rd_idx;
  logic             rd_valid, rd_dirty;
  logic [TAG_W-1:0] rd_tag;
  logic             upd_en, upd_valid, upd_dirty;
  logic [IDX_W-1:0] upd_idx;
  logic             lk_valid, lk_dirty;
  logic [TAG_W-1:0] lk_tag;
  logic             fill_ok;
  logic             unused_offsets;

  assign cur_inv        = cur_cfg.inv;
  assign cur_wb_on_inv  = cur_cfg.wb_on_inv;
  assign fill_ok        = fill_en && !eng_busy;
  assign unused_offsets = ^{fill_addr[OFF_W-1:0], look_addr[OFF_W-1:0], op_done};

  dcm_regif #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .busy       (eng_busy),
    .reg_rdata  (reg_rdata),
    .reg_wait   (reg_wait),
    .ctrl_dis   (ctrl_dis),
    .ctrl_mode  (ctrl_mode),
    .cmd_accept (cmd_accept),
    .cmd_start  (cmd_start),
    .cmd_cfg    (cmd_cfg),
    .cmd_idx    (cmd_idx),
    .cmd_tag    (cmd_tag)
  );

  dcm_tag_array #(
    .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_ok),
    .fill_idx   (fill_addr[OFF_W +: IDX_W]),
    .fill_tag   (fill_addr[OFF_W+IDX_W +: TAG_W]),
    .fill_dirty (fill_dirty),
    .upd_en     (upd_en),
    .upd_idx    (upd_idx),
    .upd_valid  (upd_valid),
    .upd_dirty  (upd_dirty),
    .rd_idx     (rd_idx),
    .rd_valid   (rd_valid),
    .rd_dirty   (rd_dirty),
    .rd_tag     (rd_tag),
    .lk_idx     (look_addr[OFF_W +: IDX_W]),
    .lk_valid   (lk_valid),
    .lk_dirty   (lk_dirty),
    .lk_tag     (lk_tag)
  );

  dcm_engine #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .SETS(SETS)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cmd_start),
    .start_cfg (cmd_cfg),
    .start_idx (cmd_idx),
    .start_tag (cmd_tag),
    .rd_idx    (rd_idx),
    .rd_valid  (rd_valid),
    .rd_dirty  (rd_dirty),
    .rd_tag    (rd_tag),
    .upd_en    (upd_en),
    .upd_idx   (upd_idx),
    .upd_valid (upd_valid),
    .upd_dirty (upd_dirty),
    .wb_valid  (wb_valid),
    .wb_ready  (wb_ready),
    .wb_addr   (wb_addr),
    .busy      (eng_busy),
    .cur_cfg   (cur_cfg),
    .op_done   (op_done)
  );

  assign look_hit   = lk_valid && lk_tag == look_addr[OFF_W+IDX_W +: TAG_W];
  assign look_dirty = lk_dirty;

endmodule

// File: rtl/dcm_ctrl_chk.sv
module dcm_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              eng_busy,
  input logic              cmd_accept,
  input logic              ctrl_dis,
  input logic              ctrl_mode,
  input logic              cur_inv,
  input logic              cur_wb_on_inv
);

  // R9
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

  // R3
  dis_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && ctrl_dis) |=> !eng_busy);

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && !ctrl_dis) |=> eng_busy);

  // R4
  discard_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && cur_inv && !cur_wb_on_inv) |-> !wb_valid);

  // R10
  ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |=> ($stable(ctrl_dis) && $stable(ctrl_mode)));

endmodule

bind dcm_ctrl dcm_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wb_valid      (wb_valid),
  .wb_ready      (wb_ready),
  .wb_addr       (wb_addr),
  .eng_busy      (eng_busy),
  .cmd_accept    (cmd_accept),
  .ctrl_dis      (ctrl_dis),
  .ctrl_mode     (ctrl_mode),
  .cur_inv       (cur_inv),
  .cur_wb_on_inv (cur_wb_on_inv)
);

// File: tb/sim_dcm_ctrl.sv
`timescale 1ns/1ps
module sim_dcm_ctrl;

  localparam int AW   = 32;
  localparam int SETS = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          reg_wait;
  logic          fill_en = 1'b0, fill_dirty = 1'b0;
  logic [AW-1:0] fill_addr = '0, look_addr = '0;
  logic          look_hit, look_dirty;
  logic          wb_valid, wb_ready;
  logic [AW-1:0] wb_addr;

  int            n_chk = 0, n_fail = 0;
  int            ready_mode = 0;   // 0 always ready, 1 toggling, 2 held low
  int            wb_cnt = 0;
  logic [AW-1:0] wb_log [64];

  always #2 clk = ~clk;

  dcm_ctrl #(.ADDR_W(AW), .LINE_BYTES(32), .SETS(SETS)) u0 (.*);

  // line base address: tag above bit 9, set index in bits 8..5
  function automatic logic [AW-1:0] la(input int tag, input int idx);
    return (AW'(tag) << 9) | (AW'(idx) << 5);
  endfunction

  // write-back responder and logger
  initial begin
    wb_ready = 1'b0;
    forever begin
      @(negedge clk);
      case (ready_mode)
        0:       wb_ready = 1'b1;
        1:       wb_ready = ~wb_ready;
        default: wb_ready = 1'b0;
      endcase
      #1;
      if (wb_valid && wb_ready && wb_cnt < 64) begin
        wb_log[wb_cnt] = wb_addr;
        wb_cnt++;
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    report();
    $finish;
  end

  task automatic check(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    #1;
    while (reg_wait) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [AW-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic fill(input logic [AW-1:0] a, input logic dirty);
    @(negedge clk);
    fill_en = 1'b1; fill_addr = a; fill_dirty = dirty;
    @(posedge clk);
    #1;
    fill_en = 1'b0;
  endtask

  task automatic probe(input logic [AW-1:0] a, output logic hit, output logic dirty);
    @(negedge clk);
    look_addr = a;
    #1;
    hit = look_hit;
    dirty = look_dirty;
  endtask

  task automatic wait_idle(output int n);
    logic [AW-1:0] d;
    n = 0;
    forever begin
      reg_read(3'd0, d);
      if (!d[8] || n > 2000) break;
      n++;
    end
  endtask

  task automatic clear_all();
    int n;
    reg_write(3'd0, 32'h0);
    reg_write(3'd1, 32'h0);
    wait_idle(n);
    wb_cnt = 0;
  endtask

  task automatic t_reset();
    logic [AW-1:0] d;
    logic h, dt;
    reg_read(3'd0, d);
    check("R1", "ctrl after reset", d, 32'h0);
    check("R1", "wb_valid after reset", AW'(wb_valid), 32'h0);
    probe(la(5, 7), h, dt);
    check("R1", "no hit after reset", AW'(h), 32'h0);
  endtask

  task automatic t_ctrl();
    logic [AW-1:0] d;
    reg_write(3'd0, 32'hFFFF_FFFF);
    reg_read(3'd0, d);
    check("R2", "ctrl only bits 0,6 writable, status 0", d, 32'h41);
    reg_write(3'd0, 32'h0);
    reg_read(3'd0, d);
    check("R2", "ctrl cleared", d, 32'h0);
  endtask

  task automatic t_whole_discard();
    int n;
    logic h, dt;
    fill(la(1, 0), 1'b1);
    fill(la(2, 3), 1'b1);
    fill(la(3, 15), 1'b0);
    wb_cnt = 0;
    reg_write(3'd1, 32'h1234);
    wait_idle(n);
    check("R8", "busy cycles, no write-backs", AW'(n), AW'(SETS));
    check("R4", "no write-back on discard", AW'(wb_cnt), 32'h0);
    probe(la(2, 3), h, dt);
    check("R4", "dirty line dropped", AW'(h), 32'h0);
    probe(la(3, 15), h, dt);
    check("R4", "last set dropped", AW'(h), 32'h0);
  endtask

  task automatic t_whole_flush();
    int n;
    logic h, dt;
    ready_mode = 0;
    fill(la(10, 2), 1'b1);
    fill(la(11, 5), 1'b0);
    fill(la(12, 9), 1'b1);
    wb_cnt = 0;
    reg_write(3'd2, 32'h0);
    wait_idle(n);
    check("R8", "busy cycles with two write-backs", AW'(n), AW'(SETS + 2));
    check("R6", "write-back count", AW'(wb_cnt), 32'd2);
    check("R6", "first write-back address", wb_log[0], la(10, 2));
    check("R6", "second write-back address", wb_log[1], la(12, 9));
    probe(la(10, 2), h, dt);
    check("R6", "flushed line stays valid", AW'(h), 32'h1);
    check("R6", "flushed line clean", AW'(dt), 32'h0);
    probe(la(11, 5), h, dt);
    check("R6", "clean line untouched", AW'(h), 32'h1);
    clear_all();
  endtask

  task automatic t_whole_inv_wb();
    int n;
    logic h, dt;
    reg_write(3'd0, 32'h40);
    ready_mode = 1;
    fill(la(17, 1), 1'b1);
    fill(la(18, 14), 1'b1);
    fill(la(19, 6), 1'b0);
    wb_cnt = 0;
    reg_write(3'd1, 32'hFFFF);
    wait_idle(n);
    check("R5", "write-back count", AW'(wb_cnt), 32'd2);
    check("R5", "first write-back address", wb_log[0], la(17, 1));
    check("R5", "second write-back address", wb_log[1], la(18, 14));
    probe(la(18, 14), h, dt);
    check("R5", "dirty line dropped", AW'(h), 32'h0);
    probe(la(19, 6), h, dt);
    check("R5", "clean line dropped", AW'(h), 32'h0);
    ready_mode = 0;
    reg_write(3'd0, 32'h0);
  endtask

  task automatic t_line();
    int n;
    logic h, dt;
    ready_mode = 0;
    wb_cnt = 0;
    fill(la(33, 3), 1'b1);
    reg_write(3'd4, la(34, 3));
    wait_idle(n);
    check("R7", "tag mismatch: no write-back", AW'(wb_cnt), 32'h0);
    probe(la(33, 3), h, dt);
    check("R7", "tag mismatch: line still dirty", AW'(dt), 32'h1);
    reg_write(3'd4, la(33, 3) | 32'h1F);
    wait_idle(n);
    check("R7", "line flush write-back count", AW'(wb_cnt), 32'd1);
    check("R7", "line flush address aligned", wb_log[0], la(33, 3));
    probe(la(33, 3), h, dt);
    check("R7", "line flush keeps valid clean", AW'({h, dt}), 32'h2);
    reg_write(3'd3, la(40, 8));
    wait_idle(n);
    check("R7", "invalid line: no write-back", AW'(wb_cnt), 32'd1);
    fill(la(33, 3), 1'b1);
    reg_write(3'd3, la(33, 3) | 32'h4);
    wait_idle(n);
    check("R11", "mode 0 line invalidate no write-back", AW'(wb_cnt), 32'd1);
    probe(la(33, 3), h, dt);
    check("R11", "mode 0 line dropped", AW'(h), 32'h0);
    fill(la(33, 3), 1'b1);
    reg_write(3'd0, 32'h40);
    reg_write(3'd3, la(33, 3));
    wait_idle(n);
    check("R11", "mode 1 line invalidate writes back", AW'(wb_cnt), 32'd2);
    check("R11", "mode 1 write-back address", wb_log[1], la(33, 3));
    probe(la(33, 3), h, dt);
    check("R11", "mode 1 line dropped", AW'(h), 32'h0);
    reg_write(3'd0, 32'h0);
  endtask

  task automatic t_disable();
    logic [AW-1:0] d;
    logic h, dt;
    wb_cnt = 0;
    fill(la(49, 4), 1'b1);
    reg_write(3'd0, 32'h1);
    reg_read(3'd0, d);
    check("R3", "reports disabled", d, 32'h1);
    reg_write(3'd1, 32'h0);
    reg_read(3'd0, d);
    check("R3", "status stays 0 when disabled", d, 32'h1);
    reg_write(3'd4, la(49, 4));
    repeat (3) @(negedge clk);
    probe(la(49, 4), h, dt);
    check("R3", "line untouched when disabled", AW'({h, dt}), 32'h3);
    check("R3", "no write-back when disabled", AW'(wb_cnt), 32'h0);
    reg_write(3'd0, 32'h41);
    reg_write(3'd0, 32'h0);
    reg_read(3'd0, d);
    check("R3", "enable sequence", d, 32'h0);
    clear_all();
  endtask

  task automatic t_wait();
    int n;
    logic [AW-1:0] d;
    ready_mode = 2;
    fill(la(65, 0), 1'b1);
    wb_cnt = 0;
    reg_write(3'd2, 32'h0);
    repeat (4) @(negedge clk);
    reg_read(3'd0, d);
    check("R8", "status held while write-back stalls", AW'(d[8]), 32'h1);
    check("R10", "read does not wait", AW'(reg_wait), 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h40;
    #1;
    check("R10", "write while busy waits", AW'(reg_wait), 32'h1);
    repeat (2) @(negedge clk);
    #1;
    check("R10", "write still waiting", AW'(reg_wait), 32'h1);
    ready_mode = 0;
    while (reg_wait) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
    wait_idle(n);
    reg_read(3'd0, d);
    check("R10", "stalled write applied", d, 32'h40);
    check("R10", "single write-back", AW'(wb_cnt), 32'd1);
    reg_write(3'd0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_whole_discard();
    t_whole_flush();
    t_whole_inv_wb();
    t_line();
    t_disable();
    t_wait();
    report();
    $finish;
  end

endmodule